// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block brings up the digital reference of a multiphase buck regulator in a controlled way. It waits until every start condition holds: both supply power-on flags are good, the enable comparator is high, and the 5-bit voltage-identification input is not the all-ones code. It then waits a fixed number of switching-clock ticks. After that it raises an internal reference code by one 12.5 mV step after every fixed group of ticks, until the code reaches the target. The ramp is therefore linear. Ramping from zero to a target code T takes T × 16 ticks.

The block also handles an output that is already charged when start-up begins. During the ramp, the power-stage drive enable is held low for as long as the feedback comparator reports that feedback is above the ramping reference. Once the reference passes feedback, the drive enable goes high and stays high. If feedback is still above the reference when the ramp ends, because the output was charged above the target, the drive enable is forced high when the ramp ends. After start-up the reference follows the target code directly. If any start condition drops, the sequence is aborted at once.

Top module: `ss_ramp_seq`

## Requirements
- R1: In the cycle after a synchronous reset, ref_code is 0 and drv_en and ss_done are low.
- R2: A sequence starts only when vcc_ok, pvcc_ok and en_cmp are all 1 and vid is not 5'b11111. Otherwise ref_code stays 0 and drv_en stays low.
- R3: After the start conditions become true, the sequencer counts 16 ph_tick pulses before the ramp begins. ref_code stays 0 throughout this delay.
- R4: During the ramp, ref_code rises by exactly 1 on every 16th ph_tick and never changes at any other time. Cycles without a tick do not advance any count.
- R5: ref_code never exceeds target_code during the ramp. ss_done rises in the same cycle in which ref_code first equals target_code. A target_code lowered during the ramp ends the ramp at the new value. If target_code is 0, the sequencer finishes directly when the delay ends.
- R6: During the ramp, drv_en stays low while fb_above is 1. It goes high in the cycle after fb_above is seen low, and stays high from then on.
- R7: If fb_above stays 1 for the whole ramp, drv_en goes high in the same cycle as ss_done.
- R8: If any start condition is false in a cycle, then in the next cycle ref_code is 0 and drv_en and ss_done are low. A new sequence, starting again with the delay, begins when the conditions return.
- R9: Once ss_done is high, ref_code equals the target_code of the previous cycle, with no ramp.
- R10: drv_en is low while the sequencer is idle or in the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ok | input | 1 | Control supply power-on good |
| pvcc_ok | input | 1 | Driver supply power-on good |
| en_cmp | input | 1 | Enable comparator output, 1 when its input is above threshold |
| vid | input | 5 | Voltage-identification code; 5'b11111 means output off |
| target_code | input | REF_W (8) | Final reference code, in 12.5 mV steps |
| ph_tick | input | 1 | One-cycle pulse per switching-clock cycle |
| fb_above | input | 1 | 1 when feedback is above the ramping reference |
| ref_code | output | REF_W (8) | Registered reference code |
| drv_en | output | 1 | Registered power-stage drive enable |
| ss_done | output | 1 | Registered soft-start-complete flag |

## Verification
All three outputs are registered, so every response to inputs applied before a rising edge appears right after that edge. The bench drives inputs on the falling edge, advances its reference model with the same inputs, and compares outputs on the next falling edge. Step timing is measured in ticks, not cycles. Tick density is therefore varied, from every cycle down to random gaps, to show that the ramp depends only on the ticks.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RAMP  = 2'd2,
    ST_RUN   = 2'd3
  } ss_state_t;
endpackage

// File: rtl/ss_enable_qual.sv
module ss_enable_qual #(
  parameter int VID_W = 5
) (
  input  logic             vcc_ok,
  input  logic             pvcc_ok,
  input  logic             en_cmp,
  input  logic [VID_W-1:0] vid,
  output logic             en_ok
);
  // The all-ones identification code means "output off".
  logic vid_off;
  assign vid_off = &vid;
  assign en_ok   = vcc_ok & pvcc_ok & en_cmp & ~vid_off;
endmodule

// File: rtl/ss_tick_div.sv
module ss_tick_div #(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic wrap
);
  localparam int CNT_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

  logic [CNT_W-1:0] cnt;

  assign wrap = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  // The count never passes its last value.
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt <= LAST); // R4
endmodule

// File: rtl/ss_ramp_seq.sv
module ss_ramp_seq #(
  parameter int REF_W      = 8,
  parameter int VID_W      = 5,
  parameter int DLY_TICKS  = 16,
  parameter int STEP_TICKS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vcc_ok,
  input  logic             pvcc_ok,
  input  logic             en_cmp,
  input  logic [VID_W-1:0] vid,
  input  logic [REF_W-1:0] target_code,
  input  logic             ph_tick,
  input  logic             fb_above,
  output logic [REF_W-1:0] ref_code,
  output logic             drv_en,
  output logic             ss_done
);
  import ss_pkg::*;

  ss_state_t  state;
  logic       en_ok;
  logic       dly_wrap;
  logic       step_wrap;
  logic [REF_W-1:0] ref_inc;

  assign ref_inc = ref_code + 1'b1;

  ss_enable_qual #(.VID_W(VID_W)) i_qual (
    .vcc_ok (vcc_ok),
    .pvcc_ok(pvcc_ok),
    .en_cmp (en_cmp),
    .vid    (vid),
    .en_ok  (en_ok)
  );

  // Two separate dividers, each one held clear outside its own phase.
  ss_tick_div #(.N(DLY_TICKS)) i_dly_div (
    .clk (clk),
    .rst (rst),
    .clr (state != ST_DELAY),
    .tick(ph_tick),
    .wrap(dly_wrap)
  );

  ss_tick_div #(.N(STEP_TICKS)) i_step_div (
    .clk (clk),
    .rst (rst),
    .clr (state != ST_RAMP),
    .tick(ph_tick),
    .wrap(step_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst || !en_ok) begin
      state    <= ST_IDLE;
      ref_code <= '0;
      drv_en   <= 1'b0;
      ss_done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_DELAY;
        end
        ST_DELAY: begin
          if (dly_wrap) begin
            if (target_code == '0) begin
              state   <= ST_RUN;
              ss_done <= 1'b1;
              drv_en  <= 1'b1;
            end else begin
              state <= ST_RAMP;
            end
          end
        end
        ST_RAMP: begin
          if (ref_code >= target_code) begin
            // The target was lowered to or below the present code.
            ref_code <= target_code;
            state    <= ST_RUN;
            ss_done  <= 1'b1;
            drv_en   <= 1'b1;
          end else begin
            if (!fb_above) drv_en <= 1'b1;
            if (step_wrap) begin
              ref_code <= ref_inc;
              if (ref_inc == target_code) begin
                state   <= ST_RUN;
                ss_done <= 1'b1;
                drv_en  <= 1'b1;
              end
            end
          end
        end
        default: begin
          ref_code <= target_code;
          ss_done  <= 1'b1;
          drv_en   <= 1'b1;
        end
      endcase
    end
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !$past(en_ok) |-> (ref_code == '0 && !drv_en && !ss_done)); // R8
  AST_DONE_TRACKS: assert property (@(posedge clk) disable iff (rst)
    ss_done |-> ref_code == $past(target_code)); // R9
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_RAMP && state == ST_RAMP) |->
      (ref_code == $past(ref_code) || ref_code == $past(ref_inc))); // R4
  AST_DRV_HELD: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_RAMP && state == ST_RAMP && !$past(drv_en) && $past(fb_above))
      |-> !drv_en); // R6
  AST_DRV_STICKY: assert property (@(posedge clk) disable iff (rst)
    (drv_en && en_ok) |=> drv_en); // R6
  AST_DELAY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DELAY || state == ST_IDLE) |-> (!drv_en && ref_code == '0)); // R10
endmodule

// File: tb/test_ss_ramp_seq.sv
module test_ss_ramp_seq;
  localparam int REF_W = 8;
  localparam int TK    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vcc_ok = 1'b0, pvcc_ok = 1'b0, en_cmp = 1'b0;
  logic [4:0] vid = 5'b11111;
  logic [REF_W-1:0] target_code = '0;
  logic ph_tick = 1'b0;
  logic fb_above = 1'b0;
  logic [REF_W-1:0] ref_code;
  logic drv_en, ss_done;

  always #4 clk = ~clk;

  ss_ramp_seq #(.REF_W(REF_W)) i_ss_ramp_seq (
    .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .pvcc_ok(pvcc_ok), .en_cmp(en_cmp),
    .vid(vid), .target_code(target_code), .ph_tick(ph_tick), .fb_above(fb_above),
    .ref_code(ref_code), .drv_en(drv_en), .ss_done(ss_done)
  );

  int n_run = 0, n_fail = 0;
  int tick_pct = 100;
  bit finished = 0;
  string cur_tag = "R1";

  // Reference model, built from the requirements.
  int m_st = 0, m_cnt = 0, m_ref = 0, m_drv = 0, m_done = 0;

  function automatic void model_step();
    bit ok;
    ok = vcc_ok && pvcc_ok && en_cmp && (vid != 5'b11111);
    if (rst || !ok) begin
      m_st = 0; m_cnt = 0; m_ref = 0; m_drv = 0; m_done = 0;
    end else begin
      case (m_st)
        0: begin m_st = 1; m_cnt = 0; end
        1: if (ph_tick) begin
             if (m_cnt == TK - 1) begin
               m_cnt = 0;
               if (target_code == 0) begin m_st = 3; m_done = 1; m_drv = 1; end
               else m_st = 2;
             end else m_cnt++;
           end
        2: begin
             if (m_ref >= int'(target_code)) begin
               m_ref = int'(target_code); m_st = 3; m_done = 1; m_drv = 1;
             end else begin
               if (!fb_above) m_drv = 1;
               if (ph_tick) begin
                 if (m_cnt == TK - 1) begin
                   m_cnt = 0; m_ref++;
                   if (m_ref == int'(target_code)) begin m_st = 3; m_done = 1; m_drv = 1; end
                 end else m_cnt++;
               end
             end
           end
        default: begin m_ref = int'(target_code); m_done = 1; m_drv = 1; end
      endcase
    end
  endfunction

  task automatic cyc();
    ph_tick = (($urandom % 100) < tick_pct);
    model_step();
    @(posedge clk);
    @(negedge clk);
    n_run++;
    if (!finished && (int'(ref_code) != m_ref || int'(drv_en) != m_drv || int'(ss_done) != m_done)) begin
      n_fail++;
      $display("FAIL %s: ref=%0d exp %0d, drv_en=%0d exp %0d, done=%0d exp %0d",
               cur_tag, ref_code, m_ref, drv_en, m_drv, ss_done, m_done);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic all_on(input logic [4:0] v);
    vcc_ok = 1; pvcc_ok = 1; en_cmp = 1; vid = v;
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    cur_tag = "R1"; rst = 1; run(3);
    rst = 0; run(2);

    // Start condition blocked by the off code, then by each flag.
    cur_tag = "R2"; target_code = 8'd5; all_on(5'b11111); run(80);
    all_on(5'b00100); vcc_ok = 0; run(40);
    vcc_ok = 1; pvcc_ok = 0; run(40);
    pvcc_ok = 1; en_cmp = 0; run(40);

    // Nominal ramp, a tick every cycle, feedback low.
    cur_tag = "R3"; tick_pct = 100; target_code = 8'd6; fb_above = 0;
    all_on(5'b01010); run(20);
    cur_tag = "R10"; run(1);
    cur_tag = "R4"; run(100);
    cur_tag = "R5"; run(10);

    // Abort mid-ramp, then restart with sparse ticks.
    cur_tag = "R8"; en_cmp = 0; target_code = 8'd4; run(2); en_cmp = 1; run(60);
    vcc_ok = 0; run(1); vcc_ok = 1;
    cur_tag = "R4"; tick_pct = 35; run(250);

    // Output charged below target: feedback high for part of the ramp.
    cur_tag = "R6"; tick_pct = 100; en_cmp = 0; run(1);
    fb_above = 1; target_code = 8'd8; en_cmp = 1; run(60);
    fb_above = 0; run(1); fb_above = 1; run(100);

    // Output charged above target: feedback high throughout.
    cur_tag = "R7"; en_cmp = 0; run(1); fb_above = 1; target_code = 8'd4;
    en_cmp = 1; run(100);

    // Target changes once start-up has finished.
    cur_tag = "R9"; target_code = 8'd9; run(1); target_code = 8'd3; run(3);
    target_code = 8'hFF; run(2);

    // Target lowered during the ramp, and a zero target.
    cur_tag = "R5"; en_cmp = 0; run(1); fb_above = 0; target_code = 8'd10; en_cmp = 1;
    run(60); target_code = 8'd1; run(5);
    en_cmp = 0; run(1); target_code = 8'd0; en_cmp = 1; run(25);

    // Random mix.
    cur_tag = "R4"; tick_pct = 60;
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 200) == 0) en_cmp = ~en_cmp;
      if (($urandom % 400) == 0) vcc_ok = ~vcc_ok;
      if (($urandom % 500) == 0) vid = (($urandom % 4) == 0) ? 5'b11111 : 5'(($urandom));
      if (($urandom % 300) == 0) target_code = REF_W'($urandom % 13);
      if (($urandom % 40) == 0) fb_above = ~fb_above;
      if (vid == 5'b11111 && ($urandom % 50) == 0) vid = 5'b00001;
      cyc();
    end

    // Final reset check.
    cur_tag = "R1"; rst = 1; run(1); rst = 0;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule